// File: doc/BRIEF.md
# P-256 Word-Serial Modular Reducer with Predicted Correction

This block takes a 512-bit integer, normally the full product of two field elements, and returns it reduced modulo p = 2^256 − 2^224 + 2^192 + 2^96 − 1. There is no divider. The upper half of the input is split into 32-bit pieces. Those pieces are regrouped into eight 256-bit terms. The low half of the input forms one further term. A fixed signed combination of all nine terms is congruent to the input modulo p, and that sum lies strictly between −4p and 5p.

The sum is built one 16-bit column at a time. Each column goes through a chain of eight add/subtract stages, and a signed carry passes from one column to the next. A look-ahead unit sums only the top column at the moment the request is accepted. From that column it predicts how many multiples of p must be removed, limited to the range −4 to +4. A first serial pass adds or subtracts that multiple, which it takes from a small constant table. The prediction can be off by one. A second serial pass therefore forms R + p and R − p side by side, and a final step keeps whichever of R, R + p and R − p lies in [0, p). The result is then loaded into an output register and a one-cycle done strobe is raised.

Top module: `p256_reduce`

## Requirements
- R1: When done_o is high, res_o equals the integer value of prod_i (bit 0 least significant) taken modulo p.
- R2: done_o goes high after the 53rd rising edge, counting the edge that accepts start_i as the first. It stays high for exactly one cycle.
- R3: A start_i that arrives while a reduction is in progress is ignored. The result and the done timing of the reduction in flight do not change, and no further done_o follows.
- R4: Every result is fully reduced (res_o < p). This includes inputs whose nine-term sum lies near its negative extreme or its positive extreme, where the predicted multiple is clamped to ±4.
- R5: res_o changes only at the edge that raises done_o, or under reset.
- R6: A synchronous active-high rst clears done_o and res_o to zero. A reset in the middle of a reduction abandons it, and no done_o follows.
- R7: prod_i is sampled only on the edge that accepts start_i. Changes to it afterwards do not affect the result.
- R8: Inputs below p come out unchanged, and an input equal to p gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a reduction; accepted only when idle |
| prod_i | input | 512 | Value to reduce, as 32 little-endian 16-bit words |
| res_o | output | 256 | Reduced value, registered |
| done_o | output | 1 | One-cycle strobe when res_o is updated |

## Verification
The bench drives inputs whose term sums are dominated by positive terms, and inputs dominated by negative terms. If the look-ahead clamp or the sign handling were wrong, these inputs would give a result one or more multiples of p away, or a value at or above p. It includes p itself, p − 1, (p − 1)^2, p^2 and all-ones. If the final three-way choice were wrong, these would return p instead of 0 or lose a borrow in the top word. Further tests raise start_i in the middle of a run, change prod_i after it has been accepted, and reset during a run. A design that restarted, re-sampled its input or kept running after reset would show a wrong value or a stray done strobe.

// File: rtl/p256_red_pkg.sv
package p256_red_pkg;

  localparam int PRIME_W = 256;
  localparam int SRC_W   = 32;
  localparam int NPOS    = PRIME_W / SRC_W;
  localparam int NTERM   = 8;
  localparam int MAX_K   = 4;

  localparam logic [PRIME_W-1:0] PRIME =
    256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;

  // source 32-bit word of the product for each term and word position (pos 0 first)
  localparam logic [4:0] NO_SRC = 5'd31;
  localparam logic [4:0] TERM_SRC [NTERM][NPOS] = '{
    '{NO_SRC, NO_SRC, NO_SRC, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15},  // doubled
    '{NO_SRC, NO_SRC, NO_SRC, 5'd12, 5'd13, 5'd14, 5'd15, NO_SRC}, // doubled
    '{5'd8,   5'd9,   5'd10,  NO_SRC, NO_SRC, NO_SRC, 5'd14, 5'd15},
    '{5'd9,   5'd10,  5'd11,  5'd13,  5'd14,  5'd15,  5'd13, 5'd8},
    '{5'd11,  5'd12,  5'd13,  NO_SRC, NO_SRC, NO_SRC, 5'd8,  5'd10},
    '{5'd12,  5'd13,  5'd14,  5'd15,  NO_SRC, NO_SRC, 5'd9,  5'd11},
    '{5'd13,  5'd14,  5'd15,  5'd8,   5'd9,   5'd10,  NO_SRC, 5'd12},
    '{5'd14,  5'd15,  NO_SRC, 5'd9,   5'd10,  5'd11,  NO_SRC, 5'd13}
  };
  localparam int TERM_GAIN [NTERM] = '{2, 2, 1, 1, -1, -1, -1, -1};

  typedef enum logic [2:0] {
    ST_IDLE, ST_SUM, ST_COR1, ST_COR2, ST_FIN
  } red_state_e;

endpackage

// File: rtl/p256_col_sum.sv
module p256_col_sum
  import p256_red_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ACC_W  = WORD_W + 5,
  parameter int CW     = 5
) (
  input  logic [2*PRIME_W-1:0]     prod_i,
  input  logic [CW-1:0]            col_i,
  output logic signed [ACC_W-1:0]  sum_o
);

  localparam int HALVES = SRC_W / WORD_W;
  localparam int NCOL   = PRIME_W / WORD_W;

  int   pos;
  int   half;
  logic valid;
  logic [WORD_W-1:0] base_w;

  always_comb begin
    valid  = int'(col_i) < NCOL;
    pos    = valid ? int'(col_i) / HALVES : 0;
    half   = valid ? int'(col_i) % HALVES : 0;
    base_w = valid ? prod_i[int'(col_i)*WORD_W +: WORD_W] : '0;
  end

  logic signed [ACC_W-1:0] chain [NTERM+1];
  assign chain[0] = $signed(ACC_W'(base_w));

  for (genvar g = 0; g < NTERM; g++) begin : g_stage
    logic [WORD_W-1:0]       w;
    logic signed [ACC_W-1:0] wx;
    always_comb begin
      w = '0;
      if (valid && TERM_SRC[g][pos] != NO_SRC)
        w = prod_i[int'(TERM_SRC[g][pos])*SRC_W + half*WORD_W +: WORD_W];
    end
    assign wx = $signed(ACC_W'(w));
    if (TERM_GAIN[g] == 2) begin : g_dbl
      assign chain[g+1] = chain[g] + (wx <<< 1);
    end else if (TERM_GAIN[g] > 0) begin : g_add
      assign chain[g+1] = chain[g] + wx;
    end else begin : g_sub
      assign chain[g+1] = chain[g] - wx;
    end
  end

  assign sum_o = chain[NTERM];

endmodule

// File: rtl/p256_ser_add.sv
module p256_ser_add #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              first_i,
  input  logic              sub_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] y_o
);

  localparam int SW = WORD_W + 2;

  logic signed [1:0]    cy_q;
  logic signed [SW-1:0] ax, bx, cin, sum;

  always_comb begin
    ax  = $signed(SW'(a_i));
    bx  = $signed(SW'(b_i));
    cin = first_i ? '0 : {{(SW-2){cy_q[1]}}, cy_q};
    sum = ax + (sub_i ? -bx : bx) + cin;
    y_o = sum[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       cy_q <= '0;
    else if (en_i) cy_q <= sum[SW-1:WORD_W];
  end

endmodule

// File: rtl/p256_reduce.sv
module p256_reduce
  import p256_red_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [2*PRIME_W-1:0] prod_i,
  output logic [PRIME_W-1:0]   res_o,
  output logic                 done_o
);

  localparam int NW    = PRIME_W / WORD_W + 1;
  localparam int CW    = $clog2(NW);
  localparam int ACC_W = WORD_W + 5;
  localparam int EXT_W = NW * WORD_W;
  localparam int KW    = $clog2(MAX_K + 1);
  localparam logic [EXT_W-1:0] PX = EXT_W'(PRIME);
  localparam logic signed [ACC_W-1:0] K_LIM = ACC_W'(MAX_K);

  red_state_e state;
  logic [CW-1:0] cnt;
  logic          last;
  logic [2*PRIME_W-1:0] prod_q;
  logic          k_neg;
  logic [KW-1:0] k_abs;

  logic [WORD_W-1:0] s_sr [NW];
  logic [WORD_W-1:0] r_sr [NW];
  logic [WORD_W-1:0] a_sr [NW];
  logic [WORD_W-1:0] b_sr [NW];

  assign last = (cnt == CW'(NW - 1));

  // column sum over the nine terms
  logic signed [ACC_W-1:0] col_sum, col_tot, col_cy;
  p256_col_sum #(.WORD_W(WORD_W), .ACC_W(ACC_W), .CW(CW)) u_col (
    .prod_i(prod_q), .col_i(cnt), .sum_o(col_sum)
  );
  assign col_tot = col_sum + ((cnt == '0) ? '0 : col_cy);

  // look-ahead on the top column of the incoming product
  logic signed [ACC_W-1:0] la_sum, la_est;
  logic                    la_neg;
  logic [KW-1:0]           la_abs;
  p256_col_sum #(.WORD_W(WORD_W), .ACC_W(ACC_W), .CW(CW)) u_look (
    .prod_i(prod_i), .col_i(CW'(PRIME_W / WORD_W - 1)), .sum_o(la_sum)
  );
  always_comb begin
    la_est = (la_sum - $signed(ACC_W'(la_sum[WORD_W-1:0]))) >>> WORD_W;
    if (la_est > K_LIM) begin
      la_neg = 1'b0; la_abs = KW'(MAX_K);
    end else if (la_est < -K_LIM) begin
      la_neg = 1'b1; la_abs = KW'(MAX_K);
    end else if (la_est < 0) begin
      la_neg = 1'b1; la_abs = KW'(-la_est);
    end else begin
      la_neg = 1'b0; la_abs = KW'(la_est);
    end
  end

  // constant table of small multiples of p
  logic [EXT_W-1:0] kp_rom [MAX_K+1];
  for (genvar g = 0; g <= MAX_K; g++) begin : g_kp
    localparam logic [EXT_W-1:0] KV = PX * EXT_W'(g);
    assign kp_rom[g] = KV;
  end

  logic [EXT_W-1:0]  kp_sel;
  logic [WORD_W-1:0] kp_word, p_word, cor1_w, addp_w, subp_w;
  always_comb begin
    kp_sel  = kp_rom[k_abs];
    kp_word = kp_sel[int'(cnt)*WORD_W +: WORD_W];
    p_word  = PX[int'(cnt)*WORD_W +: WORD_W];
  end

  // first correction: remove the predicted multiple
  p256_ser_add #(.WORD_W(WORD_W)) u_cor1 (
    .clk(clk), .rst(rst), .en_i(state == ST_COR1), .first_i(cnt == '0),
    .sub_i(~k_neg), .a_i(s_sr[0]), .b_i(kp_word), .y_o(cor1_w)
  );
  // second correction: R + p and R - p side by side
  p256_ser_add #(.WORD_W(WORD_W)) u_addp (
    .clk(clk), .rst(rst), .en_i(state == ST_COR2), .first_i(cnt == '0),
    .sub_i(1'b0), .a_i(r_sr[0]), .b_i(p_word), .y_o(addp_w)
  );
  p256_ser_add #(.WORD_W(WORD_W)) u_subp (
    .clk(clk), .rst(rst), .en_i(state == ST_COR2), .first_i(cnt == '0),
    .sub_i(1'b1), .a_i(r_sr[0]), .b_i(p_word), .y_o(subp_w)
  );

  // word shift registers
  logic              sh_s, sh_r, sh_ab;
  logic [WORD_W-1:0] s_in, r_in;
  always_comb begin
    sh_s  = (state == ST_SUM) || (state == ST_COR1);
    s_in  = (state == ST_SUM) ? col_tot[WORD_W-1:0] : '0;
    sh_r  = (state == ST_COR1) || (state == ST_COR2);
    r_in  = (state == ST_COR1) ? cor1_w : r_sr[0];
    sh_ab = (state == ST_COR2);
  end

  always_ff @(posedge clk) begin
    if (sh_s) begin
      for (int i = 0; i < NW-1; i++) s_sr[i] <= s_sr[i+1];
      s_sr[NW-1] <= s_in;
    end
    if (sh_r) begin
      for (int i = 0; i < NW-1; i++) r_sr[i] <= r_sr[i+1];
      r_sr[NW-1] <= r_in;
    end
    if (sh_ab) begin
      for (int i = 0; i < NW-1; i++) begin
        a_sr[i] <= a_sr[i+1];
        b_sr[i] <= b_sr[i+1];
      end
      a_sr[NW-1] <= addp_w;
      b_sr[NW-1] <= subp_w;
    end
  end

  // final three-way choice by top word
  logic [PRIME_W-1:0] res_next;
  always_comb begin
    for (int i = 0; i < NW-1; i++) begin
      if (b_sr[NW-1] == '0)
        res_next[i*WORD_W +: WORD_W] = b_sr[i];
      else if (a_sr[NW-1] == '0 && r_sr[NW-1] != '0)
        res_next[i*WORD_W +: WORD_W] = a_sr[i];
      else
        res_next[i*WORD_W +: WORD_W] = r_sr[i];
    end
  end

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      done_o <= 1'b0;
      res_o  <= '0;
      k_neg  <= 1'b0;
      k_abs  <= '0;
      col_cy <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          prod_q <= prod_i;
          k_neg  <= la_neg;
          k_abs  <= la_abs;
          cnt    <= '0;
          state  <= ST_SUM;
        end
        ST_SUM: begin
          col_cy <= col_tot >>> WORD_W;
          cnt    <= last ? '0 : cnt + 1'b1;
          if (last) state <= ST_COR1;
        end
        ST_COR1: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) state <= ST_COR2;
        end
        ST_COR2: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) state <= ST_FIN;
        end
        ST_FIN: begin
          res_o  <= res_next;
          done_o <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/p256_reduce_chk.sv
module p256_reduce_chk
  import p256_red_pkg::*;
#(
  parameter int LAT = 3 * (PRIME_W / 16 + 1) + 2
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               done_o,
  input logic [PRIME_W-1:0] res_o
);

  logic       busy;
  logic [7:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_i && (!busy || done_o)) begin
      busy <= 1'b1;
      cnt  <= 8'd1;
    end else if (done_o) begin
      busy <= 1'b0;
    end else if (busy && cnt != 8'hff) begin
      cnt <= cnt + 8'd1;
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (busy && cnt == 8'(LAT)));

  assert_below_p_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (res_o < PRIME));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_o) |-> (done_o || $past(rst)));

endmodule

bind p256_reduce p256_reduce_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o), .res_o(res_o)
);

// File: tb/p256_reduce_tb.sv
module p256_reduce_tb;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT    = 53;
  localparam logic [255:0] P_TB =
    256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;
  localparam logic [511:0] PX_TB = {256'd0, P_TB};
  localparam int NVEC = 11;
  localparam logic [511:0] VEC [NVEC] = '{
    512'd0,
    512'd1,
    PX_TB,
    PX_TB - 512'd1,
    {512{1'b1}},
    {{256{1'b1}}, 256'd0},
    {{160{1'b1}}, 96'd0, {256{1'b1}}},
    {160'd0, {96{1'b1}}, 256'd0},
    {8{64'hffffffff00000000}},
    PX_TB * PX_TB,
    (PX_TB - 512'd1) * (PX_TB - 512'd1)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [511:0] prod_i = '0;
  logic [255:0] res_o;
  logic done_o;

  int errors = 0;
  int checks = 0;
  logic [63:0] rng = 64'h9e3779b97f4a7c15;

  always #(CLK_PERIOD/2) clk = ~clk;

  p256_reduce u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .prod_i(prod_i),
    .res_o(res_o), .done_o(done_o)
  );

  function automatic logic [255:0] ref_mod(input logic [511:0] c);
    logic [511:0] r;
    r = c % PX_TB;
    return r[255:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] next_vec();
    logic [511:0] v;
    for (int i = 0; i < 8; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      v[i*64 +: 64] = rng;
    end
    return v;
  endfunction

  // one reduction; optionally pokes start mid-run; prod_i scrambled after acceptance
  task automatic run_op(input logic [511:0] c, input bit poke,
                        input logic [511:0] other, input string tag);
    int n;
    logic [255:0] got;
    @(negedge clk);
    prod_i = c;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    prod_i = other;
    n = 1;
    while (!done_o && n < 200) begin
      start_i = (poke && n == 20);
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    got = res_o;
    check(got == ref_mod(c), {tag, " R1 value"}, got, ref_mod(c));
    check(got < P_TB, {tag, " R4 below p"}, got, P_TB);
    check(n == EXP_LAT, {tag, " R2 latency"}, 256'(n), 256'(EXP_LAT));
    @(negedge clk);
    check(!done_o, {tag, " R2 single-cycle done"}, 256'(done_o), 256'd0);
    check(res_o == got, {tag, " R5 hold"}, res_o, got);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seen;
    logic [511:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    check(done_o == 1'b0, "R6 done after reset", 256'(done_o), 256'd0);
    check(res_o == '0, "R6 result after reset", res_o, 256'd0);

    // table walk: R1, R4, R8 and extreme-sum patterns
    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i], 1'b0, ~VEC[i], "table");
      if (i == 2) check(res_o == '0, "R8 input p gives zero", res_o, 256'd0);
      if (i == 3) check(res_o == P_TB - 256'd1, "R8 p-1 unchanged", res_o, P_TB - 256'd1);
    end
    run_op({256'd0, 256'h1234}, 1'b0, '0, "small");
    check(res_o == 256'h1234, "R8 small value unchanged", res_o, 256'h1234);

    // pseudo-random products
    for (int i = 0; i < 40; i++) begin
      v = next_vec();
      run_op(v, 1'b0, next_vec(), "random");
    end

    // R3 start while busy ignored; R7 prod_i changed after acceptance
    v = next_vec();
    run_op(v, 1'b1, {512{1'b1}}, "R3/R7 busy-start");
    check(res_o == ref_mod(v), "R7 input sampled at start only", res_o, ref_mod(v));
    seen = 0;
    repeat (70) begin
      @(negedge clk);
      if (done_o) seen++;
    end
    check(seen == 0, "R3 no extra done", 256'(seen), 256'd0);

    // R6 reset mid-run
    @(negedge clk);
    prod_i = next_vec();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(res_o == '0, "R6 result cleared mid-run", res_o, 256'd0);
    check(done_o == 1'b0, "R6 done cleared mid-run", 256'(done_o), 256'd0);
    seen = 0;
    repeat (70) begin
      @(negedge clk);
      if (done_o) seen++;
    end
    check(seen == 0, "R6 abandoned run gives no done", 256'(seen), 256'd0);

    // back to normal after reset
    run_op(VEC[10], 1'b0, '0, "after reset R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule